// File: doc/BRIEF.md
# Arbiter Configuration Error Checker

This block inspects the programmed settings of a multi-port weighted round-robin arbiter and reports the combinations that are not legal. It reads one ordering value per port, one relative-priority weight per port and priority level, and a mask that pairs ports for weight sharing. When the init strobe is asserted it evaluates four error conditions and latches them into a four-bit error vector. In the same cycle it latches the scan order the arbiter should adopt at initialization.

The scan order normally lists ports by ascending ordering value. When pairing is in use and the configuration carries an ordering or sharing error, all sharing information is dropped and the scan order becomes plain port-number order. Without pairing, ports whose ordering values collide are ranked among themselves by port number. A single-cycle interrupt pulse marks any error bit that newly becomes set. A clear input zeroes the vector and leaves the scan order as it is.

Top module: `arb_cfg_checker`

## Requirements
- R1: After reset the error vector is 0, the interrupt is low and the scan order is port-number order (slot k holds port k).
- R2: Error bit 0 is set when two or more ports carry the same ordering value.
- R3: Error bit 1 is set when any weight field of any port at any priority level equals zero.
- R4: Error bit 2 is set when at least two ports are marked in the sharing mask and their weight sets (all levels) are not identical.
- R5: Error bit 3 is set when at least two ports are marked in the sharing mask and their ordering values do not form a run of consecutive integers, in any order; a duplicate among them counts as a break. With fewer than two marked ports, neither bit 2 nor bit 3 is set.
- R6: The error vector and scan order change only at an init strobe, which loads the newly evaluated values on that clock edge. A clear without init zeroes the error vector on the next edge and leaves the scan order unchanged.
- R7: The interrupt is high for exactly the one cycle in which the latched error vector first shows a bit that was 0 before; re-latching the same or fewer bits gives no pulse.
- R8: scan_o slot k sits at bits [k*W +: W], with W = ceil(log2 ports). For a valid configuration, slot k holds the port with the k-th smallest ordering value.
- R9: When the mask has any bit set and error bit 0, 2 or 3 is set, the latched scan order is port-number order.
- R10: With no port marked and error bit 0 set, ports are ranked by ordering value, and ports sharing a value are ranked by ascending port number.
- R11: When init and clear are asserted in the same cycle, init takes precedence and the newly evaluated vector is loaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_i | input | 1 | Evaluate the configuration and latch the results |
| clr_i | input | 1 | Zero the latched error vector |
| ord_i | input | NPORT*ORD_W | Ordering value of port p at bits [p*ORD_W +: ORD_W] |
| wgt_i | input | NPORT*NLVL*WGT_W | Weight of port p, level l at bits [(p*NLVL+l)*WGT_W +: WGT_W] |
| share_i | input | NPORT | Weight-sharing mask, bit p marks port p |
| err_o | output | 4 | Latched error vector, bits 0 to 3 as in R2 to R5 |
| irq_o | output | 1 | One-cycle pulse on a newly set error bit |
| scan_o | output | NPORT*$clog2(NPORT) | Latched effective scan order, one port index per slot |

## Verification
The bench builds the block with its defaults: five ports, two priority levels, a three-bit ordering field and a four-bit weight field. The three-bit field admits ordering values above the port count, so gaps in a paired run and unused values can be set up alongside duplicates. Two levels make it possible to place a sharing mismatch or a zero weight in the second level only. With five ports, one pair can sit between unpaired ports, which shows whether fallback reorders everything and whether duplicate ties fall to the lower port number.

// File: rtl/arb_cfg_pkg.sv
package arb_cfg_pkg;
   localparam int ERR_BITS  = 4;
   localparam int ERR_DUP   = 0;
   localparam int ERR_ZERO  = 1;
   localparam int ERR_SHWGT = 2;
   localparam int ERR_SHSEQ = 3;
   typedef logic [ERR_BITS-1:0] cfg_err_t;
endpackage

// File: rtl/arb_cfg_order_chk.sv
module arb_cfg_order_chk #(
   parameter int NPORT = 5,
   parameter int ORD_W = 3
) (
   input  logic [NPORT*ORD_W-1:0] ord_i,
   input  logic [NPORT-1:0]       share_i,
   output logic                   dup_o,
   output logic                   seq_o
);
   logic [ORD_W-1:0] ov [NPORT];

   for (genvar p = 0; p < NPORT; p++) begin : g_ov
      assign ov[p] = ord_i[p*ORD_W +: ORD_W];
   end

   logic             any_dup, shr_dup;
   logic [ORD_W-1:0] mx, mn;
   int               cnt;

   always_comb begin
      any_dup = 1'b0;
      shr_dup = 1'b0;
      for (int p = 0; p < NPORT; p++) begin
         for (int q = p + 1; q < NPORT; q++) begin
            if (ov[p] == ov[q]) begin
               any_dup = 1'b1;
               if (share_i[p] && share_i[q]) shr_dup = 1'b1;
            end
         end
      end
   end

   always_comb begin
      mx  = '0;
      mn  = '1;
      cnt = 0;
      for (int p = 0; p < NPORT; p++) begin
         if (share_i[p]) begin
            cnt = cnt + 1;
            if (ov[p] > mx) mx = ov[p];
            if (ov[p] < mn) mn = ov[p];
         end
      end
   end

   assign dup_o = any_dup;
   assign seq_o = (cnt >= 2) &&
                  (shr_dup || ((int'(mx) - int'(mn)) != (cnt - 1)));
endmodule

// File: rtl/arb_cfg_weight_chk.sv
module arb_cfg_weight_chk #(
   parameter int NPORT = 5,
   parameter int NLVL  = 2,
   parameter int WGT_W = 4
) (
   input  logic [NPORT*NLVL*WGT_W-1:0] wgt_i,
   input  logic [NPORT-1:0]            share_i,
   output logic                        zero_o,
   output logic                        mis_o
);
   localparam int SET_W = NLVL * WGT_W;

   logic [SET_W-1:0]      wset [NPORT];
   logic [NPORT*NLVL-1:0] zfld;

   for (genvar p = 0; p < NPORT; p++) begin : g_port
      assign wset[p] = wgt_i[p*SET_W +: SET_W];
      for (genvar l = 0; l < NLVL; l++) begin : g_lvl
         assign zfld[p*NLVL + l] = (wgt_i[(p*NLVL + l)*WGT_W +: WGT_W] == '0);
      end
   end

   assign zero_o = |zfld;

   always_comb begin
      mis_o = 1'b0;
      for (int p = 0; p < NPORT; p++) begin
         for (int q = p + 1; q < NPORT; q++) begin
            if (share_i[p] && share_i[q] && (wset[p] != wset[q])) mis_o = 1'b1;
         end
      end
   end
endmodule

// File: rtl/arb_cfg_scan_rank.sv
module arb_cfg_scan_rank #(
   parameter int NPORT = 5,
   parameter int ORD_W = 3,
   parameter int IDX_W = 3
) (
   input  logic [NPORT*ORD_W-1:0] ord_i,
   input  logic                   fallback_i,
   output logic [NPORT*IDX_W-1:0] scan_o
);
   logic [ORD_W-1:0] key  [NPORT];
   logic [IDX_W-1:0] rank [NPORT];

   for (genvar p = 0; p < NPORT; p++) begin : g_key
      assign key[p] = fallback_i ? '0 : ord_i[p*ORD_W +: ORD_W];
   end

   always_comb begin
      for (int p = 0; p < NPORT; p++) begin
         int r;
         r = 0;
         for (int q = 0; q < NPORT; q++) begin
            if ((key[q] < key[p]) || ((key[q] == key[p]) && (q < p))) r = r + 1;
         end
         rank[p] = IDX_W'(r);
      end
   end

   always_comb begin
      scan_o = '0;
      for (int k = 0; k < NPORT; k++) begin
         for (int p = 0; p < NPORT; p++) begin
            if (rank[p] == IDX_W'(k)) scan_o[k*IDX_W +: IDX_W] = IDX_W'(p);
         end
      end
   end
endmodule

// File: rtl/arb_cfg_checker.sv
module arb_cfg_checker
   import arb_cfg_pkg::*;
#(
   parameter int NPORT = 5,
   parameter int NLVL  = 2,
   parameter int ORD_W = 3,
   parameter int WGT_W = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          init_i,
   input  logic                          clr_i,
   input  logic [NPORT*ORD_W-1:0]        ord_i,
   input  logic [NPORT*NLVL*WGT_W-1:0]   wgt_i,
   input  logic [NPORT-1:0]              share_i,
   output logic [ERR_BITS-1:0]           err_o,
   output logic                          irq_o,
   output logic [NPORT*$clog2(NPORT)-1:0] scan_o
);
   localparam int IDX_W = $clog2(NPORT);

   if (NPORT < 2) begin : g_bad_nport
      $error("arb_cfg_checker: NPORT must be at least 2");
   end
   if (NLVL < 1) begin : g_bad_nlvl
      $error("arb_cfg_checker: NLVL must be at least 1");
   end
   if (ORD_W < 1) begin : g_bad_ordw
      $error("arb_cfg_checker: ORD_W must be at least 1");
   end
   if (WGT_W < 1) begin : g_bad_wgtw
      $error("arb_cfg_checker: WGT_W must be at least 1");
   end

   logic dup, seq, zero, mis, fallback;

   arb_cfg_order_chk #(.NPORT(NPORT), .ORD_W(ORD_W)) u_order (
      .ord_i   (ord_i),
      .share_i (share_i),
      .dup_o   (dup),
      .seq_o   (seq)
   );

   arb_cfg_weight_chk #(.NPORT(NPORT), .NLVL(NLVL), .WGT_W(WGT_W)) u_weight (
      .wgt_i   (wgt_i),
      .share_i (share_i),
      .zero_o  (zero),
      .mis_o   (mis)
   );

   cfg_err_t err_c, err_d, err_q;

   always_comb begin
      err_c            = '0;
      err_c[ERR_DUP]   = dup;
      err_c[ERR_ZERO]  = zero;
      err_c[ERR_SHWGT] = mis;
      err_c[ERR_SHSEQ] = seq;
   end

   assign fallback = (|share_i) && (dup || mis || seq);

   logic [NPORT*IDX_W-1:0] scan_c, scan_q;

   arb_cfg_scan_rank #(.NPORT(NPORT), .ORD_W(ORD_W), .IDX_W(IDX_W)) u_rank (
      .ord_i      (ord_i),
      .fallback_i (fallback),
      .scan_o     (scan_c)
   );

   always_comb begin
      if (init_i)     err_d = err_c;
      else if (clr_i) err_d = '0;
      else            err_d = err_q;
   end

   logic irq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_q <= '0;
         irq_q <= 1'b0;
         for (int k = 0; k < NPORT; k++) scan_q[k*IDX_W +: IDX_W] <= IDX_W'(k);
      end else begin
         err_q <= err_d;
         irq_q <= |(err_d & ~err_q);
         if (init_i) scan_q <= scan_c;
      end
   end

   assign err_o  = err_q;
   assign irq_o  = irq_q;
   assign scan_o = scan_q;
endmodule

// File: rtl/arb_cfg_checker_sva.sv
module arb_cfg_checker_sva #(
   parameter int NPORT = 5,
   parameter int NLVL  = 2,
   parameter int ORD_W = 3,
   parameter int WGT_W = 4
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic                           init_i,
   input logic                           clr_i,
   input logic [NPORT*ORD_W-1:0]         ord_i,
   input logic [NPORT*NLVL*WGT_W-1:0]    wgt_i,
   input logic [NPORT-1:0]               share_i,
   input logic [3:0]                     err_o,
   input logic                           irq_o,
   input logic [NPORT*$clog2(NPORT)-1:0] scan_o
);
   localparam int IDX_W = $clog2(NPORT);

   logic [NPORT*IDX_W-1:0] ident;
   logic                   perm_ok;

   always_comb begin
      for (int k = 0; k < NPORT; k++) ident[k*IDX_W +: IDX_W] = IDX_W'(k);
   end

   always_comb begin
      perm_ok = 1'b1;
      for (int p = 0; p < NPORT; p++) begin
         int c;
         c = 0;
         for (int k = 0; k < NPORT; k++) begin
            if (scan_o[k*IDX_W +: IDX_W] == IDX_W'(p)) c = c + 1;
         end
         if (c != 1) perm_ok = 1'b0;
      end
   end

   // R7
   irq_newbit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> ((err_o & ~$past(err_o)) != 4'b0));

   // R6
   err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!init_i && !clr_i) |=> $stable(err_o));

   // R6
   scan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !init_i |=> $stable(scan_o));

   // R6
   clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !init_i) |=> (err_o == 4'b0));

   // R8
   scan_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      perm_ok);

   // R9
   fallback_ident_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(init_i) && (|$past(share_i)) && (err_o[0] || err_o[2] || err_o[3]))
      |-> (scan_o == ident));

   // R5
   lone_share_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (init_i && ($countones(share_i) < 2)) |=> (!err_o[2] && !err_o[3]));
endmodule

bind arb_cfg_checker arb_cfg_checker_sva #(
   .NPORT(NPORT), .NLVL(NLVL), .ORD_W(ORD_W), .WGT_W(WGT_W)
) u_sva (
   .clk(clk), .rst_n(rst_n), .init_i(init_i), .clr_i(clr_i),
   .ord_i(ord_i), .wgt_i(wgt_i), .share_i(share_i),
   .err_o(err_o), .irq_o(irq_o), .scan_o(scan_o)
);

// File: tb/tb_arb_cfg_checker.sv
`timescale 1ns/1ps
module tb_arb_cfg_checker;
   localparam int NP = 5;
   localparam int NL = 2;
   localparam int OW = 3;
   localparam int WW = 4;
   localparam int IW = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic init_i = 1'b0;
   logic clr_i = 1'b0;
   logic [NP*OW-1:0]    ord_i;
   logic [NP*NL*WW-1:0] wgt_i;
   logic [NP-1:0]       share_i = '0;
   logic [3:0]          err_o;
   logic                irq_o;
   logic [NP*IW-1:0]    scan_o;

   int ordv [NP];
   int wgtv [NP][NL];

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   always #2.5 clk = ~clk;

   always_comb begin
      for (int p = 0; p < NP; p++) begin
         ord_i[p*OW +: OW] = OW'(ordv[p]);
         for (int l = 0; l < NL; l++) wgt_i[(p*NL+l)*WW +: WW] = WW'(wgtv[p][l]);
      end
   end

   arb_cfg_checker #(.NPORT(NP), .NLVL(NL), .ORD_W(OW), .WGT_W(WW)) dut (
      .clk(clk), .rst_n(rst_n), .init_i(init_i), .clr_i(clr_i),
      .ord_i(ord_i), .wgt_i(wgt_i), .share_i(share_i),
      .err_o(err_o), .irq_o(irq_o), .scan_o(scan_o)
   );

   // behavioural reference
   int m_err;
   int m_irq;
   int m_scan [NP];

   function automatic int calc_err();
      int e, cnt, mx, mn;
      int q_ord[$];
      e = 0;
      for (int p = 0; p < NP; p++)
         for (int q = 0; q < NP; q++)
            if (p != q && ordv[p] == ordv[q]) e = e | 1;
      for (int p = 0; p < NP; p++)
         for (int l = 0; l < NL; l++)
            if (wgtv[p][l] == 0) e = e | 2;
      for (int p = 0; p < NP; p++) if (share_i[p]) q_ord.push_back(ordv[p]);
      cnt = q_ord.size();
      if (cnt >= 2) begin
         for (int p = 0; p < NP; p++)
            for (int q = 0; q < NP; q++)
               if (share_i[p] && share_i[q])
                  for (int l = 0; l < NL; l++)
                     if (wgtv[p][l] != wgtv[q][l]) e = e | 4;
         q_ord.sort();
         for (int i = 1; i < cnt; i++)
            if (q_ord[i] != q_ord[i-1] + 1) e = e | 8;
      end
      return e;
   endfunction

   task automatic calc_scan(input int e);
      bit used [NP];
      bit fb;
      fb = (share_i != 0) && ((e & 13) != 0);
      for (int p = 0; p < NP; p++) used[p] = 0;
      for (int k = 0; k < NP; k++) begin
         int best;
         best = -1;
         for (int p = 0; p < NP; p++) begin
            if (!used[p]) begin
               if (best < 0) best = p;
               else if (!fb && ordv[p] < ordv[best]) best = p;
            end
         end
         used[best] = 1;
         m_scan[k] = best;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         m_err = 0;
         m_irq = 0;
         for (int k = 0; k < NP; k++) m_scan[k] = k;
      end else begin
         int ne;
         if (init_i) begin
            ne = calc_err();
            calc_scan(ne);
         end else if (clr_i) ne = 0;
         else ne = m_err;
         m_irq = ((ne & ~m_err) != 0) ? 1 : 0;
         m_err = ne;
      end
   end

   task automatic check_val(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // every-cycle comparison with the reference
   always @(negedge clk) begin
      if (rst_n) begin
         check_val("R6 err_o vs model", int'(err_o), m_err);
         check_val("R7 irq_o vs model", int'(irq_o), m_irq);
         for (int k = 0; k < NP; k++)
            check_val("R8 scan slot vs model", int'(scan_o[k*IW +: IW]), m_scan[k]);
      end
   end

   function automatic int pk(int a, int b, int c, int d, int f);
      return a | (b << 3) | (c << 6) | (d << 9) | (f << 12);
   endfunction

   task automatic set_ord(int a, int b, int c, int d, int f);
      ordv[0] = a; ordv[1] = b; ordv[2] = c; ordv[3] = d; ordv[4] = f;
   endtask

   task automatic set_wgt_all(int v);
      for (int p = 0; p < NP; p++)
         for (int l = 0; l < NL; l++) wgtv[p][l] = v;
   endtask

   task automatic do_init(bit with_clr);
      init_i = 1'b1;
      clr_i  = with_clr;
      @(negedge clk);
      init_i = 1'b0;
      clr_i  = 1'b0;
   endtask

   task automatic idle_check_irq(string tag);
      @(negedge clk);
      check_val(tag, int'(irq_o), 0);
   endtask

   always @(posedge clk) begin
      if (cyc > 20000) begin
         errors++;
         $display("FAIL watchdog expired actual=%0d expected<=20000", cyc);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      set_ord(0, 1, 2, 3, 4);
      set_wgt_all(3);
      repeat (3) @(negedge clk);
      // R1 reset state
      check_val("R1 err_o after reset", int'(err_o), 0);
      check_val("R1 irq_o after reset", int'(irq_o), 0);
      check_val("R1 scan_o after reset", int'(scan_o), pk(0, 1, 2, 3, 4));
      rst_n = 1'b1;
      @(negedge clk);

      // R8 valid configuration, sorted by ordering value
      set_ord(2, 0, 4, 1, 3);
      share_i = 5'b00000;
      do_init(0);
      check_val("R8 valid err_o", int'(err_o), 0);
      check_val("R8 valid scan_o", int'(scan_o), pk(1, 3, 0, 4, 2));
      check_val("R7 no pulse without new bit", int'(irq_o), 0);

      // R2 and R10 duplicate ordering without pairing
      set_ord(1, 1, 0, 2, 3);
      do_init(0);
      check_val("R2 dup err_o", int'(err_o), 1);
      check_val("R10 dup tie scan_o", int'(scan_o), pk(2, 0, 1, 3, 4));
      check_val("R7 pulse on new bit", int'(irq_o), 1);
      idle_check_irq("R7 pulse lasts one cycle");

      // R6 clear zeroes vector, scan held
      clr_i = 1'b1;
      @(negedge clk);
      clr_i = 1'b0;
      check_val("R6 clr err_o", int'(err_o), 0);
      check_val("R6 clr keeps scan_o", int'(scan_o), pk(2, 0, 1, 3, 4));
      check_val("R7 no pulse on clr", int'(irq_o), 0);

      // R3 zero weight at second level
      set_ord(4, 3, 2, 1, 0);
      wgtv[3][1] = 0;
      do_init(0);
      check_val("R3 zero weight err_o", int'(err_o), 2);
      check_val("R3 zero weight scan_o", int'(scan_o), pk(4, 3, 2, 1, 0));
      check_val("R7 pulse for zero weight", int'(irq_o), 1);
      set_wgt_all(3);

      // R4 and R9 paired ports with different weights
      set_ord(4, 2, 3, 1, 0);
      share_i = 5'b00110;
      wgtv[2][1] = 5;
      do_init(0);
      check_val("R4 weight mismatch err_o", int'(err_o), 4);
      check_val("R9 fallback scan_o", int'(scan_o), pk(0, 1, 2, 3, 4));
      set_wgt_all(3);

      // R5 and R9 paired ports with non-consecutive ordering
      set_ord(0, 4, 1, 3, 2);
      share_i = 5'b01001;
      do_init(0);
      check_val("R5 gap err_o", int'(err_o), 8);
      check_val("R9 fallback on gap scan_o", int'(scan_o), pk(0, 1, 2, 3, 4));

      // R5 consecutive in reverse order is legal
      set_ord(2, 0, 3, 1, 4);
      do_init(0);
      check_val("R5 reverse run err_o", int'(err_o), 0);
      check_val("R8 paired valid scan_o", int'(scan_o), pk(1, 3, 0, 2, 4));

      // R5 single marked port never raises bit 2 or 3
      set_ord(4, 3, 2, 1, 0);
      share_i = 5'b00100;
      for (int l = 0; l < NL; l++) wgtv[2][l] = 7;
      do_init(0);
      check_val("R5 lone mark err_o", int'(err_o), 0);
      check_val("R5 lone mark scan_o", int'(scan_o), pk(4, 3, 2, 1, 0));
      set_wgt_all(3);

      // R5 duplicate inside the pair, R9 fallback
      set_ord(0, 2, 2, 1, 3);
      share_i = 5'b00110;
      do_init(0);
      check_val("R5 paired dup err_o", int'(err_o), 9);
      check_val("R9 paired dup scan_o", int'(scan_o), pk(0, 1, 2, 3, 4));
      check_val("R7 pulse paired dup", int'(irq_o), 1);
      // R7 same bits again: no pulse
      do_init(0);
      check_val("R7 repeat init err_o", int'(err_o), 9);
      check_val("R7 repeat init no pulse", int'(irq_o), 0);

      // R11 init wins over clear
      set_ord(1, 1, 0, 2, 3);
      share_i = 5'b00000;
      do_init(1);
      check_val("R11 init over clr err_o", int'(err_o), 1);
      check_val("R11 fewer bits no pulse", int'(irq_o), 0);
      check_val("R11 scan_o", int'(scan_o), pk(2, 0, 1, 3, 4));

      // R8 values above the port count with a consecutive pair
      set_ord(7, 5, 6, 0, 2);
      share_i = 5'b00110;
      do_init(0);
      check_val("R8 wide values err_o", int'(err_o), 0);
      check_val("R8 wide values scan_o", int'(scan_o), pk(3, 4, 1, 2, 0));

      // R6 inputs change without init: outputs hold
      set_ord(3, 3, 3, 3, 3);
      set_wgt_all(0);
      share_i = 5'b11111;
      repeat (3) @(negedge clk);
      check_val("R6 hold err_o", int'(err_o), 0);
      check_val("R6 hold scan_o", int'(scan_o), pk(3, 4, 1, 2, 0));

      repeat (2) @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule